// File: doc/BRIEF.md
# Programmable CPU Clock Prescaler

This block turns a free-running oscillator clock into a one-cycle clock-enable pulse. The CPU and its peripherals run on the same oscillator clock and advance only on cycles where the pulse is high, so no derived clock is ever generated. The rate comes from an 8-bit divide value that software writes through a strobe. A configuration bit chooses between full rate and half rate when the divide value is zero.

A nonzero divide value N sets an even ratio of 2*(N+1) oscillator cycles, from 4 up to 512. A zero value gives a ratio of 1, or 2 when the configuration bit is set. The half-rate setting lets code written for a 12-oscillator-clock machine cycle keep its timing, where the native machine cycle is 6 enables.

Software may rewrite the divide value at any time. The value is first held as pending and becomes active only when the current period ends. The pulse train never stops, and no period is cut short.

Top module: `cpu_clk_prescaler`

## Requirements
- R1: While reset is asserted `cpuClkEn` is 0, and the active divide value resets to zero. The first pulse after reset is released appears once one full period of the reset-state ratio has elapsed: 1 cycle with `compatHalf` clear, 2 cycles with it set.
- R2: With an active divide value of 0 and `compatHalf` = 0, `cpuClkEn` is high on every oscillator cycle (ratio 1).
- R3: With an active divide value of 0 and `compatHalf` = 1, `cpuClkEn` pulses once every 2 oscillator cycles.
- R4: With an active divide value N in 1..255, `cpuClkEn` pulses once every 2*(N+1) oscillator cycles, whatever the value of `compatHalf`.
- R5: For any ratio above 1, each pulse is exactly one oscillator cycle wide.
- R6: A value written with `divWr` in the middle of a period does not change that period. The period completes at the old ratio, and the following periods use the new ratio.
- R7: A value written on the same clock edge that ends a period applies to the period that starts at that edge.
- R8: The internal period counter never exceeds the active period limit, including at the largest ratio of 512.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| divWr | input | 1 | Write strobe for the divide value |
| divData | input | 8 | Divide value N presented with `divWr` |
| compatHalf | input | 1 | Configuration bit: half rate when N is 0 (hold static) |
| cpuClkEn | output | 1 | One-cycle CPU clock-enable pulse at the divided rate |

## Verification
The active divide value, the pending value and the period counter can only be seen through the spacing of the enable pulses. A corrupted counter or limit changes the very next gap between pulses, so a bad state shows up within at most one period (512 cycles) of the fault. Loading the pending value at the wrong moment shows up as a wrong length for the period that contains the write, or for the period just after it. For this reason the bench measures the gap between pulses, and pays most attention to periods that span a write or start on one.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

  // Strobes passed from control to datapath once per oscillator cycle.
  typedef struct packed {
    logic wrap;     // current period ends on this edge
    logic capture;  // divide value written on this edge
  } ctrlStrb_t;

endpackage

// File: rtl/prescaler_datapath.sv
module prescaler_datapath
  import prescaler_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [DIV_W-1:0]     divData,
  input  logic                 compatHalf,
  output logic [DIV_W:0]       cnt,
  output logic [DIV_W:0]       lim
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] pendDiv;
  logic [DIV_W-1:0] activeDiv;
  logic [DIV_W-1:0] nextDiv;

  // The period limit is ratio-1. For N>0 the ratio is 2(N+1), so the limit is 2N+1.
  always_comb begin
    if (activeDiv == '0) lim = {{DIV_W{1'b0}}, compatHalf};
    else                 lim = {activeDiv, 1'b1};
  end

  assign nextDiv = strb.capture ? divData : pendDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendDiv   <= '0;
      activeDiv <= '0;
      cnt       <= '0;
    end else begin
      if (strb.capture) pendDiv <= divData;
      if (strb.wrap) begin
        activeDiv <= nextDiv;
        cnt       <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R8: counter stays inside the active period
  a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lim);

  // R6: the active value changes only at a period boundary
  a_r6_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrap |=> $stable(activeDiv));

endmodule

// File: rtl/prescaler_ctrl.sv
module prescaler_ctrl
  import prescaler_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWr,
  input  logic [DIV_W:0]   cnt,
  input  logic [DIV_W:0]   lim,
  output ctrlStrb_t        strb,
  output logic             tickQ
);

  always_comb begin
    strb.wrap    = (cnt == lim);
    strb.capture = divWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickQ <= 1'b0;
    else       tickQ <= strb.wrap;
  end

  // R5: a pulse is one cycle wide whenever the ratio exceeds 1
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (tickQ && lim != '0) |=> !tickQ);

endmodule

// File: rtl/cpu_clk_prescaler.sv
module cpu_clk_prescaler
  import prescaler_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWr,
  input  logic [DIV_W-1:0] divData,
  input  logic             compatHalf,
  output logic             cpuClkEn
);
  localparam int CNT_W = DIV_W + 1;

  ctrlStrb_t        strb;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             tickQ;

  prescaler_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .divWr (divWr),
    .cnt   (cnt),
    .lim   (lim),
    .strb  (strb),
    .tickQ (tickQ)
  );

  prescaler_datapath #(.DIV_W(DIV_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .divData    (divData),
    .compatHalf (compatHalf),
    .cnt        (cnt),
    .lim        (lim)
  );

  assign cpuClkEn = tickQ;

  // R1: every pulse coincides with a fresh period start
  a_r1_pulse_at_start: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> cnt == '0);

  // R3: the half-rate setting never yields back-to-back pulses
  a_r3_half_rate: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && lim == CNT_W'(1)) |=> !cpuClkEn);

endmodule

// File: tb/cpu_clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module cpu_clk_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       divWr = 1'b0;
  logic [7:0] divData = '0;
  logic       compatHalf = 1'b0;
  logic       cpuClkEn;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cpu_clk_prescaler dut_i (
    .clk(clk), .rstN(rstN), .divWr(divWr), .divData(divData),
    .compatHalf(compatHalf), .cpuClkEn(cpuClkEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts negedges until a pulse is seen; returns cycles waited.
  task automatic waitTick(output int n);
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (cpuClkEn) break;
      if (n > 2000) begin
        check(1'b0, "watchdog", n, 0);
        break;
      end
    end
  endtask

  task automatic doReset(input bit compat);
    int n;
    @(negedge clk);
    rstN = 1'b0;
    compatHalf = compat;
    divWr = 1'b0;
    @(negedge clk);
    check(cpuClkEn == 1'b0, "R1 low in reset", cpuClkEn, 0);
    rstN = 1'b1;
    waitTick(n);
    check(n == (compat ? 2 : 1), "R1 first pulse delay", n, compat ? 2 : 1);
  endtask

  // Writes a value starting at the current negedge (one cycle strobe).
  task automatic doWrite(input logic [7:0] v);
    divWr = 1'b1;
    divData = v;
    @(negedge clk);
    divWr = 1'b0;
  endtask

  task automatic measure(input int expRatio, input int reps, input string req);
    int n;
    for (int i = 0; i < reps; i++) begin
      waitTick(n);
      check(n == expRatio, req, n, expRatio);
      if (expRatio > 1) begin
        @(negedge clk);
        check(cpuClkEn == 1'b0, "R5 width", cpuClkEn, 0);
        waitTick(n);
        check(n == expRatio - 1, req, n + 1, expRatio);
      end
    end
  endtask

  task automatic setRatio(input logic [7:0] v);
    int n;
    doWrite(v);
    waitTick(n);
    waitTick(n);
  endtask

  task automatic t_unity;
    doReset(1'b0);
    measure(1, 3, "R2 unity rate");
  endtask

  task automatic t_half;
    doReset(1'b1);
    measure(2, 3, "R3 half rate");
  endtask

  task automatic t_divN;
    doReset(1'b0);
    setRatio(8'd1);
    measure(4, 2, "R4 N=1");
    setRatio(8'd5);
    measure(12, 2, "R4 N=5");
    compatHalf = 1'b1;
    setRatio(8'd2);
    measure(6, 2, "R4 N=2 compat ignored");
    compatHalf = 1'b0;
    setRatio(8'd255);
    measure(512, 1, "R4 R8 N=255");
  endtask

  task automatic t_midWrite;
    int n;
    doReset(1'b0);
    setRatio(8'd1);
    waitTick(n);
    doWrite(8'd5);
    waitTick(n);
    check(n == 3, "R6 old period completes", n + 1, 4);
    waitTick(n);
    check(n == 12, "R6 new ratio", n, 12);
    doWrite(8'd0);
    waitTick(n);
    check(n == 11, "R6 old period completes", n + 1, 12);
    waitTick(n);
    check(n == 1, "R6 new ratio unity", n, 1);
  endtask

  task automatic t_edgeWrite;
    int n;
    doReset(1'b0);
    setRatio(8'd5);
    waitTick(n);
    repeat (11) @(negedge clk);
    divWr = 1'b1;
    divData = 8'd1;
    @(negedge clk);
    divWr = 1'b0;
    check(cpuClkEn == 1'b1, "R7 boundary pulse", cpuClkEn, 1);
    waitTick(n);
    check(n == 4, "R7 write at boundary", n, 4);
  endtask

  initial begin
    t_unity();
    t_half();
    t_divN();
    t_midWrite();
    t_edgeWrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule